// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small set of hardware lock tokens shared by two independent requesters, called the left and the right port. Software on either side claims a token before it touches a shared resource and hands the token back afterwards. The bank makes sure that only one side holds a given token at any time. When both sides ask for a free token in the same cycle, a fixed priority settles it.

Each port has the control pins of an asynchronous memory port, sampled on a common clock: chip enable, write enable, output enable, two byte selects, a semaphore select, a token index and a data word. A token access goes through only when the semaphore select is active and the memory itself is idle. Either the chip enable is inactive, or both byte selects are inactive. A claim that meets a token held by the other side is not dropped. It waits and completes on its own when the holder lets go. An access that tries to reach a token while the memory is also selected is discarded and reported on an error pin.

Top module: `sem_bank`

## Requirements
- R1: Reset (rst_ni low, asynchronous) makes every token free, clears all waiting claims, drives both read buses to all ones and both error pins low.
- R2: A port reaches the bank only when sem_ni is 0 and either ce_ni is 1 or both ub_ni and lb_ni are 1. With sem_ni at 1 the port has no effect on any token.
- R3: A write (we_ni = 0) with data bit 0 at 0 is a claim. If the other port does not hold the token, the writer holds it from the next clock edge on. Data bits 15 to 1 are ignored.
- R4: A write with data bit 0 at 1 releases the token if the writer holds it, and cancels any claim the writer has waiting on it. It has no effect on a token held by the other port.
- R5: A read (we_ni = 1, oe_ni = 0) updates data_o at the next edge. All 16 bits become 0 if the reader holds the token, and all become 1 if the token is free or held by the other port. Without a read, data_o keeps its value.
- R6: A claim refused because the other port holds the token stays waiting. It is granted at the same edge at which the holder's release takes effect.
- R7: If both ports claim the same free token in the same cycle, the left port gets it and the right port's claim waits.
- R8: No token is ever held by both ports at once.
- R9: With sem_ni 0, ce_ni 0 and ub_ni or lb_ni at 0, the access is refused. No token, waiting claim or read bus changes, and err_o is 1 for exactly the following cycle.
- R10: The token index is taken from addr_i, which is 3 bits wide for eight tokens, and an access touches only that token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low |
| l_we_ni | input | 1 | Left write enable, active low (1 = read) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_ub_ni | input | 1 | Left upper byte select, active low |
| l_lb_ni | input | 1 | Left lower byte select, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_addr_i | input | 3 | Left token index |
| l_data_i | input | 16 | Left write data, bit 0 used |
| l_data_o | output | 16 | Left read data, token state on every bit |
| l_err_o | output | 1 | Left refused-access pulse |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_we_ni | input | 1 | Right write enable, active low (1 = read) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_ub_ni | input | 1 | Right upper byte select, active low |
| r_lb_ni | input | 1 | Right lower byte select, active low |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_addr_i | input | 3 | Right token index |
| r_data_i | input | 16 | Right write data, bit 0 used |
| r_data_o | output | 16 | Right read data, token state on every bit |
| r_err_o | output | 1 | Right refused-access pulse |

## Verification
The assertions check four things on every cycle. No token has two holders. The read buses carry only all-zero or all-one words. A refused access raises the error pin and leaves every ownership bit unchanged. A claim on a token the other side does not hold, a release by the holder and a same-cycle tie each reach the required owner at the next edge. Only the bench scenarios can show the effects that depend on history. These are a waiting claim completing after a later release, a cancelled claim that must not complete, data_o holding through reads that are disabled or refused, and ownership being wiped by a reset in mid-run.

// File: rtl/sem_pkg.sv
`timescale 1ns/1ps
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic bad;
    logic wbit;
  } port_cmd_t;
endpackage

// File: rtl/sem_port.sv
`timescale 1ns/1ps
module sem_port
  import sem_pkg::*;
#(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(N_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic              sem_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [N_FLAGS-1:0] own_i,
  output logic [N_FLAGS-1:0] req_o,
  output logic [N_FLAGS-1:0] rel_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  port_cmd_t cmd;
  logic      mem_idle;
  logic      unused_hi;

  assign unused_hi = ^data_i[DATA_W-1:1];
  assign mem_idle  = ce_ni | (ub_ni & lb_ni);

  always_comb begin
    cmd.wr   = ~sem_ni & mem_idle & ~we_ni;
    cmd.rd   = ~sem_ni & mem_idle & we_ni & ~oe_ni;
    cmd.bad  = ~sem_ni & ~mem_idle;
    cmd.wbit = data_i[0];
  end

  always_comb begin
    for (int i = 0; i < N_FLAGS; i++) begin
      req_o[i] = cmd.wr & ~cmd.wbit & (addr_i == AW'(i));
      rel_o[i] = cmd.wr &  cmd.wbit & (addr_i == AW'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '1;
      err_o  <= 1'b0;
    end else begin
      err_o <= cmd.bad;
      if (cmd.rd) data_o <= {DATA_W{~own_i[addr_i]}};
    end
  end
endmodule

// File: rtl/sem_flag_cell.sv
`timescale 1ns/1ps
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic   want_l, want_r, keep_l, keep_r;

  always_comb begin
    want_l = (pend_l_q | req_l_i) & ~rel_l_i;
    want_r = (pend_r_q | req_r_i) & ~rel_r_i;
    keep_l = (owner_q == OWN_L) & ~rel_l_i;
    keep_r = (owner_q == OWN_R) & ~rel_r_i;
    // holder keeps; otherwise left has priority over right
    if (keep_l)      owner_d = OWN_L;
    else if (keep_r) owner_d = OWN_R;
    else if (want_l) owner_d = OWN_L;
    else if (want_r) owner_d = OWN_R;
    else             owner_d = OWN_FREE;
    pend_l_d = want_l & (owner_d != OWN_L);
    pend_r_d = want_r & (owner_d != OWN_R);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_FREE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o = (owner_q == OWN_L);
  assign own_r_o = (owner_q == OWN_R);
endmodule

// File: rtl/sem_bank.sv
`timescale 1ns/1ps
module sem_bank #(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(N_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic              l_ub_ni,
  input  logic              l_lb_ni,
  input  logic              l_sem_ni,
  input  logic [AW-1:0]     l_addr_i,
  input  logic [DATA_W-1:0] l_data_i,
  output logic [DATA_W-1:0] l_data_o,
  output logic              l_err_o,
  input  logic              r_ce_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic              r_ub_ni,
  input  logic              r_lb_ni,
  input  logic              r_sem_ni,
  input  logic [AW-1:0]     r_addr_i,
  input  logic [DATA_W-1:0] r_data_i,
  output logic [DATA_W-1:0] r_data_o,
  output logic              r_err_o
);
  logic [N_FLAGS-1:0] own_l, own_r;
  logic [N_FLAGS-1:0] req_l, rel_l, req_r, rel_r;

  sem_port #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W)) u_port_l (
    .clk_i, .rst_ni,
    .ce_ni(l_ce_ni), .we_ni(l_we_ni), .oe_ni(l_oe_ni),
    .ub_ni(l_ub_ni), .lb_ni(l_lb_ni), .sem_ni(l_sem_ni),
    .addr_i(l_addr_i), .data_i(l_data_i), .own_i(own_l),
    .req_o(req_l), .rel_o(rel_l), .data_o(l_data_o), .err_o(l_err_o)
  );

  sem_port #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W)) u_port_r (
    .clk_i, .rst_ni,
    .ce_ni(r_ce_ni), .we_ni(r_we_ni), .oe_ni(r_oe_ni),
    .ub_ni(r_ub_ni), .lb_ni(r_lb_ni), .sem_ni(r_sem_ni),
    .addr_i(r_addr_i), .data_i(r_data_i), .own_i(own_r),
    .req_o(req_r), .rel_o(rel_r), .data_o(r_data_o), .err_o(r_err_o)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i, .rst_ni,
      .req_l_i(req_l[g]), .rel_l_i(rel_l[g]),
      .req_r_i(req_r[g]), .rel_r_i(rel_r[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end
endmodule

// File: rtl/sem_bank_chk.sv
`timescale 1ns/1ps
module sem_bank_chk #(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(N_FLAGS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_ce_ni, l_we_ni, l_ub_ni, l_lb_ni, l_sem_ni,
  input logic [AW-1:0]      l_addr_i,
  input logic               l_wbit_i,
  input logic               r_ce_ni, r_we_ni, r_ub_ni, r_lb_ni, r_sem_ni,
  input logic [AW-1:0]      r_addr_i,
  input logic               r_wbit_i,
  input logic [DATA_W-1:0]  l_data_o,
  input logic [DATA_W-1:0]  r_data_o,
  input logic               l_err_o,
  input logic               r_err_o,
  input logic [N_FLAGS-1:0] own_l,
  input logic [N_FLAGS-1:0] own_r
);
  logic l_ok, r_ok, l_bad, r_bad, l_claim, r_claim, l_free;
  assign l_ok    = !l_sem_ni && (l_ce_ni || (l_ub_ni && l_lb_ni));
  assign r_ok    = !r_sem_ni && (r_ce_ni || (r_ub_ni && r_lb_ni));
  assign l_bad   = !l_sem_ni && !l_ce_ni && !(l_ub_ni && l_lb_ni);
  assign r_bad   = !r_sem_ni && !r_ce_ni && !(r_ub_ni && r_lb_ni);
  assign l_claim = l_ok && !l_we_ni && !l_wbit_i;
  assign r_claim = r_ok && !r_we_ni && !r_wbit_i;
  assign l_free  = l_ok && !l_we_ni && l_wbit_i;

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  a_r5_l_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_data_o == '0) || (l_data_o == '1));

  a_r5_r_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_data_o == '0) || (r_data_o == '1));

  a_r9_l_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_bad |=> l_err_o);

  a_r9_r_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_bad |=> r_err_o);

  a_r9_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_bad && r_sem_ni) |=> (own_l == $past(own_l)) && (own_r == $past(own_r)));

  a_r3_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_claim && !own_r[l_addr_i]) |=> own_l[$past(l_addr_i)]);

  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_free && own_l[l_addr_i]) |=> !own_l[$past(l_addr_i)]);

  a_r7_tie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_claim && r_claim && (l_addr_i == r_addr_i) && !own_l[l_addr_i] && !own_r[l_addr_i])
    |=> own_l[$past(l_addr_i)] && !own_r[$past(l_addr_i)]);
endmodule

bind sem_bank sem_bank_chk #(.N_FLAGS(N_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_ce_ni(l_ce_ni), .l_we_ni(l_we_ni), .l_ub_ni(l_ub_ni), .l_lb_ni(l_lb_ni),
  .l_sem_ni(l_sem_ni), .l_addr_i(l_addr_i), .l_wbit_i(l_data_i[0]),
  .r_ce_ni(r_ce_ni), .r_we_ni(r_we_ni), .r_ub_ni(r_ub_ni), .r_lb_ni(r_lb_ni),
  .r_sem_ni(r_sem_ni), .r_addr_i(r_addr_i), .r_wbit_i(r_data_i[0]),
  .l_data_o(l_data_o), .r_data_o(r_data_o), .l_err_o(l_err_o), .r_err_o(r_err_o),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
  localparam bit L = 1'b0;
  localparam bit R = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ctl_l, ctl_r; // {ce_n, we_n, oe_n, ub_n, lb_n}
  logic sem_l, sem_r;
  logic [2:0] a_l, a_r;
  logic [15:0] d_l, d_r, q_l, q_r;
  logic e_l, e_r;

  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    bit          side;
    bit          is_err;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t it;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sem_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(ctl_l[4]), .l_we_ni(ctl_l[3]), .l_oe_ni(ctl_l[2]),
    .l_ub_ni(ctl_l[1]), .l_lb_ni(ctl_l[0]), .l_sem_ni(sem_l),
    .l_addr_i(a_l), .l_data_i(d_l), .l_data_o(q_l), .l_err_o(e_l),
    .r_ce_ni(ctl_r[4]), .r_we_ni(ctl_r[3]), .r_oe_ni(ctl_r[2]),
    .r_ub_ni(ctl_r[1]), .r_lb_ni(ctl_r[0]), .r_sem_ni(sem_r),
    .r_addr_i(a_r), .r_data_i(d_r), .r_data_o(q_r), .r_err_o(e_r)
  );

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare queued expectations after the capturing edge
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      it = exp_q.pop_front();
      if (it.is_err) check({15'b0, it.side ? e_r : e_l}, it.val, it.tag);
      else           check(it.side ? q_r : q_l, it.val, it.tag);
    end
  end

  task automatic expect_q(bit s, bit is_err, logic [15:0] v, string tag);
    exp_t x;
    x.due = cyc + 1; x.side = s; x.is_err = is_err; x.val = v; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic idle_all();
    ctl_l = 5'b11111; ctl_r = 5'b11111; sem_l = 1'b1; sem_r = 1'b1;
    a_l = '0; a_r = '0; d_l = '0; d_r = '0;
  endtask

  task automatic put(bit s, logic [4:0] c, logic sem, int a, logic [15:0] d);
    if (s == L) begin ctl_l = c; sem_l = sem; a_l = 3'(a); d_l = d; end
    else        begin ctl_r = c; sem_r = sem; a_r = 3'(a); d_r = d; end
  endtask

  task automatic wr(bit s, int a, logic [15:0] d);
    put(s, 5'b10100, 1'b0, a, d);
  endtask

  task automatic rd(bit s, int a, logic [15:0] e, string tag);
    put(s, 5'b11000, 1'b0, a, 16'h0);
    expect_q(s, 1'b0, e, tag);
  endtask

  task automatic nxt();
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    check(q_l, 16'hFFFF, "R1 reset left bus");
    check(q_r, 16'hFFFF, "R1 reset right bus");
    check({15'b0, e_l | e_r}, 16'h0, "R1 reset err");
    rst_n = 1'b1;
    nxt();

    rd(L, 3, 16'hFFFF, "R5 free token reads ones"); nxt();
    wr(L, 3, 16'h0000); nxt();
    rd(L, 3, 16'h0000, "R3 claim granted");
    rd(R, 3, 16'hFFFF, "R5 other holder reads ones"); nxt();
    wr(R, 3, 16'h0000); nxt();
    rd(R, 3, 16'hFFFF, "R6 refused claim"); nxt();
    wr(L, 3, 16'h0001); nxt();
    rd(R, 3, 16'h0000, "R6 waiting claim granted");
    rd(L, 3, 16'hFFFF, "R4 holder released"); nxt();

    wr(L, 5, 16'h0000); wr(R, 5, 16'h0000); nxt();
    rd(L, 5, 16'h0000, "R7 left wins tie");
    rd(R, 5, 16'hFFFF, "R7 right loses tie"); nxt();
    wr(L, 5, 16'h0001); nxt();
    rd(R, 5, 16'h0000, "R6 tie loser granted on release"); nxt();

    // chip enabled but both bytes deselected: still a token access
    put(R, 5'b00111, 1'b0, 1, 16'hFFFE); nxt();
    rd(R, 1, 16'h0000, "R2 byte-deselect access, R3 bit0 only"); nxt();
    wr(L, 1, 16'h0001); nxt();
    rd(R, 1, 16'h0000, "R4 non-holder release ignored"); nxt();
    wr(L, 1, 16'h0000); nxt();
    wr(L, 1, 16'h0001); nxt();
    wr(R, 1, 16'h0001); nxt();
    rd(L, 1, 16'hFFFF, "R4 cancelled claim not granted");
    rd(R, 1, 16'hFFFF, "R4 token free after release"); nxt();

    // refused access: memory also selected
    put(L, 5'b00110, 1'b0, 6, 16'h0000);
    expect_q(L, 1'b1, 16'h0001, "R9 err raised"); nxt();
    rd(L, 6, 16'hFFFF, "R9 refused claim no grant");
    expect_q(L, 1'b1, 16'h0000, "R9 err one cycle"); nxt();

    wr(L, 7, 16'h0000); nxt();
    rd(L, 7, 16'h0000, "R10 token 7 held"); nxt();
    put(L, 5'b01000, 1'b0, 0, 16'h0000);
    expect_q(L, 1'b0, 16'h0000, "R9 refused read keeps bus");
    expect_q(L, 1'b1, 16'h0001, "R9 err on refused read"); nxt();
    put(L, 5'b11100, 1'b0, 0, 16'h0000);
    expect_q(L, 1'b0, 16'h0000, "R5 oe high keeps bus"); nxt();
    rd(L, 6, 16'hFFFF, "R10 neighbour token untouched"); nxt();

    put(L, 5'b00100, 1'b1, 2, 16'h0000); nxt();
    wr(R, 2, 16'h0000); nxt();
    rd(R, 2, 16'h0000, "R2 sem idle write ignored"); nxt();
    repeat (3) nxt();

    rst_n = 1'b0;
    @(negedge clk);
    check(q_l, 16'hFFFF, "R1 mid-run reset left bus");
    check(q_r, 16'hFFFF, "R1 mid-run reset right bus");
    rst_n = 1'b1;
    nxt();
    rd(L, 7, 16'hFFFF, "R1 token 7 freed");
    rd(R, 2, 16'hFFFF, "R1 token 2 freed"); nxt();
    wr(R, 7, 16'h0000); nxt();
    rd(R, 7, 16'h0000, "R1 R3 claim after reset"); nxt();
    repeat (3) nxt();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule